// File: doc/BRIEF.md
# Control-Store Nibble Debug Sequencer

A debugger reaches a wide microcode control store through a 4-bit window. This block is the small state machine behind that window. Each read or write command from the debugger starts a six-step sequence. The sequence halts the processor, selects the current store address and moves the nibble through the store or through a temporary holding register. When the command is released, the block advances its nibble index. The store, the address counter, the holding register and the datapath are all outside the block. They are reached only through the strobes described below.

The nibble index decides what each command touches. Indices up to 7 address the eight nibbles of a store word. The processor is held only while such an index is selected. Indices of 10 and above address the holding register. After nibble 7 the index wraps to 0 and the block pulses a request to step the store address to the next word. The debugger sets the index through a load port. Every strobe is a combinational function of the registered state, the registered index and the two live command inputs.

Top module: `cs_nibble_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the sequence state to 0 and the nibble index to 0.
- R2: In state 0 with neither command asserted, the state and the index hold. With `cmd_rd` or `cmd_wr` asserted, the next state is 1. In that same cycle, an index of 7 or less drives `run` low and `sel_addr_n` low.
- R3: In states 1 and 2, `cs_rd_en` is high exactly when either of two conditions holds: `cmd_rd` is high with an index of 9 or less, or `cmd_wr` is high with an index from 2 to 7.
- R4: In states 1 and 2, an index of 7 or less drives `run` low and `sel_addr_n` low. In state 2 with such an index, `cs_wr_en` follows `cmd_wr`. `cs_wr_en` is never high in any other state.
- R5: In states 1 and 2, `tmp_rd_n` is low when `cmd_rd` is high and the index is 10 or more. In state 2, `tmp_wr` is high whenever that condition is false.
- R6: States 3 and 4 always advance by one on the next edge. In these states `run` is low for indices of 7 or less, and `tmp_rd_n` is low whenever `cmd_rd` is high.
- R7: State 5 holds while either command stays asserted. During the hold, `tmp_rd_n` is low if `cmd_rd` is high and `run` stays high.
- R8: When both commands are low in state 5, the next state is 0. The index changes on the same edge, in one of three ways. An index of 7 becomes 0, and `step_addr_n` is low in that cycle. Any other index below 10 rises by one. An index of 10 or more is unchanged.
- R9: Any strobe not called for by R2 to R8 sits at its idle level. Idle is `run` high, `sel_addr_n`, `step_addr_n` and `tmp_rd_n` high, and `tmp_wr`, `cs_wr_en` and `cs_rd_en` low.
- R10: With `idx_load` high at a clock edge, the index takes `idx_value`. This takes precedence over the change in R8.
- R11: The state never leaves the range 0 to 5. The unused codes 6 and 7 would go to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rd | input | 1 | Debugger read command |
| cmd_wr | input | 1 | Debugger write command |
| idx_load | input | 1 | Load `idx_value` into the nibble index |
| idx_value | input | 4 | Index value to load |
| run | output | 1 | Processor run enable (low halts) |
| sel_addr_n | output | 1 | Select current store address, active low |
| step_addr_n | output | 1 | Step store address to next word, active low |
| tmp_rd_n | output | 1 | Drive holding register onto bus, active low |
| tmp_wr | output | 1 | Capture bus into holding register |
| cs_wr_en | output | 1 | Store write enable |
| cs_rd_en | output | 1 | Store read enable |
| nib_idx | output | 4 | Current nibble index |
| seq_state | output | 3 | Current sequence state |

## Verification
The strobes depend only on the state, the index and the commands. A wrong state code or index therefore shows on the strobes in the same cycle it is held, before the next edge. A skipped or repeated step shows as a strobe pattern for the wrong state, one cycle after the bad transition. An index that advances wrongly on release shows in `nib_idx` one edge later. It also shows in `step_addr_n` and in the store/holding-register choice of the next command. The bench sweeps every index with each command pattern through all six states. In each state it tries all four command combinations and compares every strobe with an independently written model.

// File: rtl/cs_nibble_pkg.sv
package cs_nibble_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_XFER  = 3'd2,
    ST_WAIT3 = 3'd3,
    ST_WAIT4 = 3'd4,
    ST_DONE  = 3'd5
  } seq_st_e;

  // Internal strobes, all active high; polarity is fixed at the top.
  typedef struct packed {
    logic halt;
    logic sel_addr;
    logic tmp_rd;
    logic tmp_wr;
    logic cs_we;
    logic cs_re;
  } strobe_t;
endpackage

// File: rtl/cs_nibble_fsm.sv
module cs_nibble_fsm
  import cs_nibble_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_any,
  output logic [ST_W-1:0] state,
  output logic            release_evt
);
  logic [ST_W-1:0] state_q, state_d;

  always_comb begin
    case (state_q)
      ST_IDLE:  state_d = cmd_any ? ST_ADDR : ST_IDLE;
      ST_ADDR:  state_d = ST_XFER;
      ST_XFER:  state_d = ST_WAIT3;
      ST_WAIT3: state_d = ST_WAIT4;
      ST_WAIT4: state_d = ST_DONE;
      ST_DONE:  state_d = cmd_any ? ST_DONE : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state       = state_q;
  assign release_evt = (state_q == ST_DONE) && !cmd_any;
endmodule

// File: rtl/cs_nibble_index.sv
module cs_nibble_index #(
  parameter int IDX_W     = 4,
  parameter int LAST_NIB  = 7,
  parameter int TEMP_BASE = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             release_evt,
  input  logic             ld,
  input  logic [IDX_W-1:0] din,
  output logic [IDX_W-1:0] idx,
  output logic             wrap_evt
);
  localparam logic [IDX_W-1:0] LAST_V = IDX_W'(LAST_NIB);
  localparam logic [IDX_W-1:0] TEMP_V = IDX_W'(TEMP_BASE);

  // Index after a released command: wrap at the last nibble, saturate in temp range.
  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] v);
    if (v == LAST_V)     return '0;
    else if (v < TEMP_V) return v + IDX_W'(1);
    else                 return v;
  endfunction

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    if (ld)               idx_d = din;
    else if (release_evt) idx_d = bump(idx_q);
    else                  idx_d = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end

  assign idx      = idx_q;
  assign wrap_evt = release_evt && (idx_q == LAST_V);
endmodule

// File: rtl/cs_nibble_decode.sv
module cs_nibble_decode
  import cs_nibble_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int LAST_NIB  = 7,
  parameter int TEMP_BASE = 10,
  parameter int RD_LIMIT  = 9,
  parameter int WR_FIRST  = 2
) (
  input  logic [ST_W-1:0]  state,
  input  logic [IDX_W-1:0] idx,
  input  logic             rd,
  input  logic             wr,
  output strobe_t          strb
);
  localparam logic [IDX_W-1:0] LAST_V = IDX_W'(LAST_NIB);
  localparam logic [IDX_W-1:0] TEMP_V = IDX_W'(TEMP_BASE);
  localparam logic [IDX_W-1:0] RDL_V  = IDX_W'(RD_LIMIT);
  localparam logic [IDX_W-1:0] WRF_V  = IDX_W'(WR_FIRST);

  logic store_nib, temp_nib, store_rd_ok, store_wr_ok, read_temp;
  assign store_nib   = idx <= LAST_V;
  assign temp_nib    = idx >= TEMP_V;
  assign store_rd_ok = rd && (idx <= RDL_V);
  assign store_wr_ok = wr && (idx >= WRF_V) && store_nib;
  assign read_temp   = rd && temp_nib;

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE: begin
        if ((rd || wr) && store_nib) begin
          strb.halt     = 1'b1;
          strb.sel_addr = 1'b1;
        end
      end
      ST_ADDR: begin
        strb.cs_re    = store_rd_ok || store_wr_ok;
        strb.halt     = store_nib;
        strb.sel_addr = store_nib;
        strb.tmp_rd   = read_temp;
      end
      ST_XFER: begin
        strb.cs_re    = store_rd_ok || store_wr_ok;
        strb.halt     = store_nib;
        strb.sel_addr = store_nib;
        strb.cs_we    = store_nib && wr;
        strb.tmp_rd   = read_temp;
        strb.tmp_wr   = !read_temp;
      end
      ST_WAIT3, ST_WAIT4: begin
        strb.halt   = store_nib;
        strb.tmp_rd = rd;
      end
      ST_DONE: begin
        strb.tmp_rd = rd;
      end
      default: strb = '0;
    endcase
  end
endmodule

// File: rtl/cs_nibble_seq.sv
module cs_nibble_seq
  import cs_nibble_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int LAST_NIB  = 7,
  parameter int TEMP_BASE = 10,
  parameter int RD_LIMIT  = 9,
  parameter int WR_FIRST  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] idx_value,
  output logic             run,
  output logic             sel_addr_n,
  output logic             step_addr_n,
  output logic             tmp_rd_n,
  output logic             tmp_wr,
  output logic             cs_wr_en,
  output logic             cs_rd_en,
  output logic [IDX_W-1:0] nib_idx,
  output logic [ST_W-1:0]  seq_state
);
  // Named internal events, visible to the bound checker.
  logic    cmd_any;
  logic    release_evt;
  logic    wrap_evt;
  strobe_t strb;

  assign cmd_any = cmd_rd || cmd_wr;

  cs_nibble_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_any     (cmd_any),
    .state       (seq_state),
    .release_evt (release_evt)
  );

  cs_nibble_index #(
    .IDX_W     (IDX_W),
    .LAST_NIB  (LAST_NIB),
    .TEMP_BASE (TEMP_BASE)
  ) u_index (
    .clk         (clk),
    .rst         (rst),
    .release_evt (release_evt),
    .ld          (idx_load),
    .din         (idx_value),
    .idx         (nib_idx),
    .wrap_evt    (wrap_evt)
  );

  cs_nibble_decode #(
    .IDX_W     (IDX_W),
    .LAST_NIB  (LAST_NIB),
    .TEMP_BASE (TEMP_BASE),
    .RD_LIMIT  (RD_LIMIT),
    .WR_FIRST  (WR_FIRST)
  ) u_decode (
    .state (seq_state),
    .idx   (nib_idx),
    .rd    (cmd_rd),
    .wr    (cmd_wr),
    .strb  (strb)
  );

  assign run         = !strb.halt;
  assign sel_addr_n  = !strb.sel_addr;
  assign step_addr_n = !wrap_evt;
  assign tmp_rd_n    = !strb.tmp_rd;
  assign tmp_wr      = strb.tmp_wr;
  assign cs_wr_en    = strb.cs_we;
  assign cs_rd_en    = strb.cs_re;
endmodule

// File: rtl/cs_nibble_seq_chk.sv
module cs_nibble_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             idx_load,
  input logic [IDX_W-1:0] idx_value,
  input logic             tmp_rd_n,
  input logic             tmp_wr,
  input logic             cs_wr_en,
  input logic             cs_rd_en,
  input logic             step_addr_n,
  input logic [IDX_W-1:0] nib_idx,
  input logic [2:0]       seq_state,
  input logic             release_evt,
  input logic             wrap_evt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (seq_state == 3'd0) && (nib_idx == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd0) && !cmd_rd && !cmd_wr && !idx_load
      |=> (seq_state == 3'd0) && $stable(nib_idx));

  // R3
  store_rd_window_chk: assert property (@(posedge clk) disable iff (rst)
    cs_rd_en |-> (seq_state == 3'd1) || (seq_state == 3'd2));

  // R4
  store_wr_window_chk: assert property (@(posedge clk) disable iff (rst)
    cs_wr_en |-> (seq_state == 3'd2) && cmd_wr);

  // R5
  temp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tmp_wr && !tmp_rd_n));

  // R6
  wait_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd3) || (seq_state == 3'd4)
      |=> seq_state == $past(seq_state) + 3'd1);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd5) && (cmd_rd || cmd_wr) |=> seq_state == 3'd5);

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !step_addr_n && !idx_load |=> (nib_idx == '0) && (seq_state == 3'd0));

  // R8
  wrap_source_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |-> release_evt);

  // R10
  load_chk: assert property (@(posedge clk) disable iff (rst)
    idx_load |=> nib_idx == $past(idx_value));

  // R11
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    seq_state <= 3'd5);
endmodule

bind cs_nibble_seq cs_nibble_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_rd      (cmd_rd),
  .cmd_wr      (cmd_wr),
  .idx_load    (idx_load),
  .idx_value   (idx_value),
  .tmp_rd_n    (tmp_rd_n),
  .tmp_wr      (tmp_wr),
  .cs_wr_en    (cs_wr_en),
  .cs_rd_en    (cs_rd_en),
  .step_addr_n (step_addr_n),
  .nib_idx     (nib_idx),
  .seq_state   (seq_state),
  .release_evt (release_evt),
  .wrap_evt    (wrap_evt)
);

// File: tb/cs_nibble_seq_bench.sv
module cs_nibble_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_rd = 1'b0, cmd_wr = 1'b0, idx_load = 1'b0;
  logic [3:0] idx_value = '0;
  logic       run, sel_addr_n, step_addr_n, tmp_rd_n, tmp_wr, cs_wr_en, cs_rd_en;
  logic [3:0] nib_idx;
  logic [2:0] seq_state;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_nibble_seq u_cs_nibble_seq (
    .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .idx_load(idx_load), .idx_value(idx_value),
    .run(run), .sel_addr_n(sel_addr_n), .step_addr_n(step_addr_n),
    .tmp_rd_n(tmp_rd_n), .tmp_wr(tmp_wr), .cs_wr_en(cs_wr_en),
    .cs_rd_en(cs_rd_en), .nib_idx(nib_idx), .seq_state(seq_state)
  );

  // Reference: {run, sel_addr_n, step_addr_n, tmp_rd_n, tmp_wr, cs_wr_en, cs_rd_en}
  function automatic logic [6:0] model(int st, int ix, bit r, bit w);
    bit lo   = ix < 8;
    bit hi   = ix > 9;
    bit any  = r | w;
    bit mid  = (st == 1) || (st == 2);
    bit wait34 = (st == 3) || (st == 4);
    logic [6:0] e;
    e[6] = !(lo && ((st == 0 && any) || mid || wait34));
    e[5] = !(lo && ((st == 0 && any) || mid));
    e[4] = !(st == 5 && !any && ix == 7);
    e[3] = !((mid && r && hi) || (wait34 && r) || (st == 5 && r));
    e[2] = (st == 2) && !(r && hi);
    e[1] = (st == 2) && lo && w;
    e[0] = mid && ((w && ix >= 2 && ix <= 7) || (r && ix <= 9));
    return e;
  endfunction

  function automatic string tags_for(int st);
    case (st)
      0:       return "R2/R9";
      1, 2:    return "R3/R4/R5/R9";
      3, 4:    return "R6/R9";
      default: return "R7/R8/R9";
    endcase
  endfunction

  task automatic check_val(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Try all four command combinations in the current state; outputs are combinational.
  task automatic sweep(int st, int ix);
    check_val("R11 state", int'(seq_state), st);
    for (int c = 0; c < 4; c++) begin
      cmd_rd = c[0];
      cmd_wr = c[1];
      #1;
      check_val($sformatf("%s st=%0d idx=%0d rd=%0d wr=%0d", tags_for(st), st, ix, c[0], c[1]),
                int'({run, sel_addr_n, step_addr_n, tmp_rd_n, tmp_wr, cs_wr_en, cs_rd_en}),
                int'(model(st, ix, c[0], c[1])));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check_val("R1 state after reset", int'(seq_state), 0);
    check_val("R1 index after reset", int'(nib_idx), 0);
    check_val("R9 idle strobes", int'({run, sel_addr_n, step_addr_n, tmp_rd_n, tmp_wr, cs_wr_en, cs_rd_en}),
              int'(7'b1111000));

    // R2 idle with no command holds
    @(negedge clk);
    @(negedge clk);
    #1;
    check_val("R2 idle hold state", int'(seq_state), 0);
    check_val("R2 idle hold index", int'(nib_idx), 0);

    for (int ix = 0; ix < 16; ix++) begin
      for (int pat = 1; pat < 4; pat++) begin
        @(negedge clk);
        cmd_rd = 1'b0; cmd_wr = 1'b0;
        idx_load = 1'b1; idx_value = 4'(ix);
        @(negedge clk);
        idx_load = 1'b0;
        #1;
        check_val("R10 load", int'(nib_idx), ix);
        for (int st = 0; st < 6; st++) begin
          sweep(st, ix);
          cmd_rd = pat[0]; cmd_wr = pat[1];
          @(negedge clk);
        end
        // still held in state 5: R7
        #1;
        check_val("R7 hold in done", int'(seq_state), 5);
        check_val("R7 index held", int'(nib_idx), ix);
        cmd_rd = 1'b0; cmd_wr = 1'b0;
        #1;
        check_val("R8 step strobe", int'(step_addr_n), (ix == 7) ? 0 : 1);
        @(negedge clk);
        #1;
        check_val("R8 back to idle", int'(seq_state), 0);
        check_val($sformatf("R8 index after release from %0d", ix), int'(nib_idx),
                  (ix == 7) ? 0 : ((ix < 10) ? ix + 1 : ix));
      end
    end

    // R10 load wins over release
    @(negedge clk);
    idx_load = 1'b1; idx_value = 4'd7;
    @(negedge clk);
    idx_load = 1'b0; cmd_rd = 1'b1;
    repeat (5) @(negedge clk);
    cmd_rd = 1'b0; idx_load = 1'b1; idx_value = 4'd12;
    @(negedge clk);
    idx_load = 1'b0;
    #1;
    check_val("R10 load over release", int'(nib_idx), 12);
    check_val("R8 idle after release", int'(seq_state), 0);

    // R1 reset mid-sequence
    @(negedge clk);
    cmd_wr = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; cmd_wr = 1'b0;
    #1;
    check_val("R1 reset mid state", int'(seq_state), 0);
    check_val("R1 reset mid index", int'(nib_idx), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule